// File: doc/BRIEF.md
# Interlocked Forward-Channel Host Transmitter

This block sends command and data bytes from a host to a peripheral over a parallel cable. It uses a fully interlocked four-edge handshake. A byte arrives on a valid/ready input port together with a flag that marks it as a command or as data. The engine drives the byte onto the bus and puts the command/data distinction on a side-band line. It then holds the bus for a programmable number of clock cycles before it lowers its active-low strobe.

After the strobe falls, the engine waits for the peripheral's acknowledge to rise, then raises the strobe again. The transfer ends only when the acknowledge falls back low. Both peripheral inputs are asynchronous, so each passes through a two-flop synchronizer before any logic uses it.

While the channel runs forward, the peripheral can pull an active-low reversal request at any moment. The engine latches that request into a sticky status flag, which stays set until the host clears it. A wait counter raises a stall flag when the peripheral leaves either wait phase of the handshake unanswered for a parameterised number of cycles.

Top module: `ecp_fwd_host`

## Requirements
- R1: After reset, `strobe_n_o` is 1, `host_ack_o` is 1, `data_o` is 0, `rev_req_o` is 0, `stall_o` is 0, and `tx_ready_o` is 1 once the synchronized acknowledge is low.
- R2: `tx_ready_o` is 1 only while the engine is idle and the synchronized acknowledge is low. A byte is accepted on a rising clock edge where `tx_valid_i` and `tx_ready_o` are both 1.
- R3: On acceptance, `data_o` takes `tx_byte_i`. `host_ack_o` takes 0 for a command (`tx_cmd_i`=1) and 1 for data (`tx_cmd_i`=0). Both hold until the next acceptance.
- R4: `strobe_n_o` falls on the (S+1)-th rising edge after the acceptance edge, where S is `setup_cycles_i` sampled at acceptance. This gives a minimum of one cycle of data setup.
- R5: `strobe_n_o` stays low until the synchronized acknowledge is high. It rises on the third rising edge that samples `pack_i` high, counting the first sampling edge.
- R6: After the strobe has risen, the transfer completes only when the synchronized acknowledge is low. The engine then returns to idle and `tx_ready_o` can return on the same edge.
- R7: A `tx_valid_i` presented while `tx_ready_o` is 0 has no effect on `data_o`, `host_ack_o` or `strobe_n_o`.
- R8: `rev_req_o` sets on the third rising edge that samples `prq_n_i` low, counting the first sampling edge. It stays set until a `rev_clr_i` edge finds the synchronized request high. A pending request wins over a clear.
- R9: `stall_o` is 1 once the engine has stayed in the same wait phase (strobe low awaiting acknowledge high, or strobe high awaiting acknowledge low) for STALL_LIMIT consecutive edges. It returns to 0 on the edge that leaves that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tx_valid_i | input | 1 | Byte offered |
| tx_ready_o | output | 1 | Engine can take a byte |
| tx_byte_i | input | DATA_W | Byte to send |
| tx_cmd_i | input | 1 | 1 = command byte, 0 = data byte |
| setup_cycles_i | input | SETUP_W | Extra setup cycles before the strobe falls |
| pack_i | input | 1 | Peripheral acknowledge, asynchronous |
| prq_n_i | input | 1 | Peripheral reversal request, active low, asynchronous |
| rev_clr_i | input | 1 | Clear the latched reversal request |
| data_o | output | DATA_W | Parallel data bus |
| strobe_n_o | output | 1 | Host strobe, active low |
| host_ack_o | output | 1 | Command/data side-band line (0 = command) |
| rev_req_o | output | 1 | Latched reversal request |
| stall_o | output | 1 | Handshake wait has reached the stall limit |

## Verification
The strobe falls S+1 edges after acceptance. An acknowledge edge on the cable reaches the strobe on the third sampling edge, and a reversal request reaches `rev_req_o` with the same three-edge latency. The bench keeps a behavioural reference model that updates on each rising edge and carries its own two-stage input delay. It compares every output against that model at each falling edge, so each result is checked on exactly the cycle it becomes due, never earlier or later. The peripheral responder in the bench varies its reaction delays so that the stall threshold is both reached and missed.

// File: rtl/ecp_fwd_pkg.sv
package ecp_fwd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_STROBE  = 2'd2,
    ST_RELEASE = 2'd3
  } fwd_state_t;
endpackage

// File: rtl/ecp_sync_bank.sv
module ecp_sync_bank #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb sh_d = {sh_q[STAGES-2:0], d_i[b]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= {STAGES{RST_VAL[b]}};
      else        sh_q <= sh_d;
    end

    assign q_o[b] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/ecp_setup_timer.sv
module ecp_setup_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  p_setup_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/ecp_stall_timer.sv
module ecp_stall_timer #(
  parameter int LIMIT = 1024,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic stall_o
);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = !hold_i || (cnt_q != LIM);
    cnt_d  = hold_i ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign stall_o = (cnt_q == LIM);

  p_stall_after_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> $past(hold_i));
endmodule

// File: rtl/ecp_fwd_fsm.sv
module ecp_fwd_fsm
  import ecp_fwd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              tx_cmd_i,
  input  logic              ack_s_i,
  input  logic              setup_zero_i,
  output logic              tx_ready_o,
  output logic              accept_o,
  output logic              hold_o,
  output logic [DATA_W-1:0] data_o,
  output logic              host_ack_o,
  output logic              strobe_n_o
);
  fwd_state_t        state_q, state_d;
  logic [DATA_W-1:0] data_q;
  logic              hack_q;

  always_comb begin
    tx_ready_o = (state_q == ST_IDLE) && !ack_s_i;
    accept_o   = tx_ready_o && tx_valid_i;
    state_d    = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept_o)     state_d = ST_SETUP;
      ST_SETUP:   if (setup_zero_i) state_d = ST_STROBE;
      ST_STROBE:  if (ack_s_i)      state_d = ST_RELEASE;
      ST_RELEASE: if (!ack_s_i)     state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
    hold_o = ((state_q == ST_STROBE) || (state_q == ST_RELEASE)) &&
             (state_d == state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      hack_q <= 1'b1;
    end else if (accept_o) begin
      data_q <= tx_byte_i;
      hack_q <= !tx_cmd_i;
    end
  end

  assign data_o     = data_q;
  assign host_ack_o = hack_q;
  assign strobe_n_o = (state_q != ST_STROBE);

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(data_q));
  p_strobe_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RELEASE && $past(state_q) == ST_STROBE) |-> $past(ack_s_i));
  p_release_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RELEASE && ack_s_i) |=> (state_q == ST_RELEASE));
endmodule

// File: rtl/ecp_fwd_host.sv
module ecp_fwd_host #(
  parameter int DATA_W      = 8,
  parameter int SETUP_W     = 4,
  parameter int STALL_LIMIT = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_valid_i,
  output logic               tx_ready_o,
  input  logic [DATA_W-1:0]  tx_byte_i,
  input  logic               tx_cmd_i,
  input  logic [SETUP_W-1:0] setup_cycles_i,
  input  logic               pack_i,
  input  logic               prq_n_i,
  input  logic               rev_clr_i,
  output logic [DATA_W-1:0]  data_o,
  output logic               strobe_n_o,
  output logic               host_ack_o,
  output logic               rev_req_o,
  output logic               stall_o
);
  logic ack_s, rq_n_s, setup_zero, accept, hold;
  logic rev_q, rev_d, rev_en;

  ecp_sync_bank #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pack_i), .q_o(ack_s));

  ecp_sync_bank #(.W(1), .STAGES(2), .RST_VAL(1'b1)) u_rq_sync (
    .clk(clk), .rst_n(rst_n), .d_i(prq_n_i), .q_o(rq_n_s));

  ecp_fwd_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .tx_valid_i(tx_valid_i), .tx_byte_i(tx_byte_i), .tx_cmd_i(tx_cmd_i),
    .ack_s_i(ack_s), .setup_zero_i(setup_zero),
    .tx_ready_o(tx_ready_o), .accept_o(accept), .hold_o(hold),
    .data_o(data_o), .host_ack_o(host_ack_o), .strobe_n_o(strobe_n_o));

  ecp_setup_timer #(.CW(SETUP_W)) u_setup (
    .clk(clk), .rst_n(rst_n),
    .load_i(accept), .load_val_i(setup_cycles_i), .zero_o(setup_zero));

  ecp_stall_timer #(.LIMIT(STALL_LIMIT)) u_stall (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .stall_o(stall_o));

  // Reversal request latch: a pending request has priority over a clear.
  always_comb begin
    rev_en = !rq_n_s || rev_clr_i;
    rev_d  = !rq_n_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rev_q <= 1'b0;
    else if (rev_en) rev_q <= rev_d;
  end

  assign rev_req_o = rev_q;

  p_rev_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rq_n_s |=> rev_req_o);
  p_rev_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_req_o && !rev_clr_i) |=> rev_req_o);
endmodule

// File: tb/ecp_fwd_host_test.sv
module ecp_fwd_host_test;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid_i = 1'b0;
  logic       tx_ready_o;
  logic [7:0] tx_byte_i = 8'h00;
  logic       tx_cmd_i = 1'b0;
  logic [3:0] setup_cycles_i = 4'd0;
  logic       pack_i = 1'b0;
  logic       prq_n_i = 1'b1;
  logic       rev_clr_i = 1'b0;
  logic [7:0] data_o;
  logic       strobe_n_o, host_ack_o, rev_req_o, stall_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecp_fwd_host #(.DATA_W(8), .SETUP_W(4), .STALL_LIMIT(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .tx_byte_i(tx_byte_i), .tx_cmd_i(tx_cmd_i),
    .setup_cycles_i(setup_cycles_i), .pack_i(pack_i), .prq_n_i(prq_n_i),
    .rev_clr_i(rev_clr_i), .data_o(data_o), .strobe_n_o(strobe_n_o),
    .host_ack_o(host_ack_o), .rev_req_o(rev_req_o), .stall_o(stall_o));

  // Behavioural reference: phase 0 idle, 1 setup, 2 strobe low, 3 strobe high
  int   m_ph, m_cnt, m_wait;
  bit   m_a1, m_a2, m_r1, m_r2, m_rev, m_hack;
  logic [7:0] m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_wait = 0;
      m_a1 = 0; m_a2 = 0; m_r1 = 1; m_r2 = 1;
      m_rev = 0; m_hack = 1; m_data = 8'h00;
    end else begin
      int nph;
      nph = m_ph;
      case (m_ph)
        0: if (tx_valid_i && !m_a2) begin
             m_data = tx_byte_i; m_hack = !tx_cmd_i;
             m_cnt = int'(setup_cycles_i); nph = 1;
           end
        1: if (m_cnt == 0) nph = 2; else m_cnt = m_cnt - 1;
        2: if (m_a2) nph = 3;
        default: if (!m_a2) nph = 0;
      endcase
      if (m_ph >= 2 && nph == m_ph) m_wait = (m_wait < LIMIT) ? m_wait + 1 : LIMIT;
      else m_wait = 0;
      m_ph = nph;
      if (!m_r2) m_rev = 1;
      else if (rev_clr_i) m_rev = 0;
      m_a2 = m_a1; m_a1 = pack_i;
      m_r2 = m_r1; m_r1 = prq_n_i;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2/R6 tx_ready_o", int'(tx_ready_o), int'(m_ph == 0 && !m_a2));
      chk("R3/R7 data_o", int'(data_o), int'(m_data));
      chk("R3/R7 host_ack_o", int'(host_ack_o), int'(m_hack));
      chk("R4/R5 strobe_n_o", int'(strobe_n_o), int'(m_ph != 2));
      chk("R8 rev_req_o", int'(rev_req_o), int'(m_rev));
      chk("R9 stall_o", int'(stall_o), int'(m_wait == LIMIT));
    end
  end

  task automatic send(input logic [7:0] b, input bit cmd, input int setup,
                      input int d_hi, input int d_lo);
    tx_byte_i = b; tx_cmd_i = cmd; setup_cycles_i = 4'(setup);
    tx_valid_i = 1'b1;
    while (!tx_ready_o) @(negedge clk);
    @(negedge clk);
    tx_valid_i = 1'b0;
    tx_byte_i = ~b;
    while (strobe_n_o) @(negedge clk);
    repeat (d_hi) @(negedge clk);
    pack_i = 1'b1;
    while (!strobe_n_o) @(negedge clk);
    repeat (d_lo) @(negedge clk);
    pack_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    chk("R1 strobe_n_o", int'(strobe_n_o), 1);
    chk("R1 host_ack_o", int'(host_ack_o), 1);
    chk("R1 data_o", int'(data_o), 0);
    chk("R1 rev_req_o", int'(rev_req_o), 0);
    chk("R1 stall_o", int'(stall_o), 0);
    chk("R1 tx_ready_o", int'(tx_ready_o), 1);

    // R3/R4: data and command bytes with several setup lengths
    send(8'hA5, 1'b0, 0, 0, 0);
    send(8'h3C, 1'b1, 3, 2, 1);
    send(8'hF0, 1'b0, 7, 1, 5);
    send(8'h0F, 1'b1, 15, 4, 0);

    // R7: valid offered while the peripheral still reports busy in idle
    pack_i = 1'b1;
    repeat (3) @(negedge clk);
    tx_byte_i = 8'h99; tx_cmd_i = 1'b1; tx_valid_i = 1'b1;
    repeat (8) @(negedge clk);
    chk("R7 data_o unchanged", int'(data_o), 8'h0F);
    pack_i = 1'b0;
    tx_valid_i = 1'b0;
    repeat (4) @(negedge clk);

    // R9: stall reached in each wait phase, and just missed
    send(8'h55, 1'b0, 1, LIMIT + 4, LIMIT + 6);
    send(8'hAA, 1'b0, 2, LIMIT - 6, LIMIT - 6);

    // R8: reversal request latching, clear priority, and clear
    prq_n_i = 1'b0;
    repeat (2) @(negedge clk);
    prq_n_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 rev latched", int'(rev_req_o), 1);
    prq_n_i = 1'b0; rev_clr_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 request beats clear", int'(rev_req_o), 1);
    prq_n_i = 1'b1;
    repeat (4) @(negedge clk);
    rev_clr_i = 1'b0;
    @(negedge clk);
    chk("R8 cleared", int'(rev_req_o), 0);

    // request pulse arriving in the middle of a transfer
    fork
      send(8'h12, 1'b0, 2, 3, 3);
      begin
        repeat (5) @(negedge clk);
        prq_n_i = 1'b0;
        @(negedge clk);
        prq_n_i = 1'b1;
      end
    join
    chk("R8 mid-transfer request", int'(rev_req_o), 1);

    repeat (5) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R6 watchdog: actual=hung expected=complete");
      summary();
      $finish;
    end
  end
endmodule